// File: doc/BRIEF.md
# Page Write Commit Engine

This block sits behind a serial memory slave and turns one write transaction into a single self-timed programming cycle on an on-chip memory array. When the slave reports the start of a write, the block records the word address, then stores each incoming data byte in a small page buffer. The buffer offset comes from the low address bits and wraps inside the page, while the upper address bits stay fixed for the whole transaction. If more bytes arrive than the page holds, the newest bytes replace the oldest ones.

When the bus STOP arrives after at least one complete byte, and the write-protect pin is low, the block raises a busy flag and runs two equal phases. The first phase erases every buffered location by writing all ones. The second phase writes the buffered data. Each phase issues at most one array write per clock, sweeping the page offsets in ascending order at the start of the phase, and then waits out the rest of the phase. The phase length is half of a cycle-length input, with a floor of one page's worth of clocks. A one-clock done pulse marks the end. While busy is high, the slave is expected to withhold acknowledges, and the block ignores all transaction inputs.

Top module: `page_commit_engine`

## Requirements
- R1: After reset `busy`, `arr_we` and `commit_done` are low.
- R2: The byte at position n (counting from 0) of a transaction is stored at page offset (start offset + n) mod PAGE_BYTES. Every array write of a commit uses the start address's upper bits, that is, all bits above the low log2(PAGE_BYTES) bits.
- R3: When more than PAGE_BYTES bytes are sent, each offset holds the last byte sent to it, and only that byte is committed there.
- R4: `arr_we` is high only while `busy` is high. It is high once per phase for each offset written in the transaction and never for any other offset.
- R5: In the erase phase every write carries all ones (8'hFF). In the program phase each write carries the buffered byte. Within each phase, writes go to ascending offsets in the phase's first PAGE_BYTES clocks.
- R6: `busy` stays high for exactly 2*P clocks, where P = max(floor(cycle_len/2), PAGE_BYTES). `cycle_len` is sampled on the clock that accepts the STOP, and later changes do not affect the running cycle.
- R7: If `wr_protect` is high when the STOP is accepted, no array write occurs and `busy` stays low.
- R8: A STOP with no complete data byte since the write began starts no commit. A `bus_start` before the STOP discards the buffered bytes.
- R9: While `busy` is high, `open_write`, `byte_valid`, `bus_start` and `bus_stop` have no effect.
- R10: `commit_done` is high for exactly one clock, the first clock after `busy` falls at the end of a commit.
- R11: Buffer valid marks clear at each new write start, so a commit writes only the offsets written in its own transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_write | input | 1 | Pulse: a write transaction begins at `word_addr` |
| word_addr | input | ADDR_W | Starting word address, valid with `open_write` |
| byte_valid | input | 1 | Pulse: one complete data byte received |
| byte_data | input | DATA_W | Data byte, valid with `byte_valid` |
| bus_start | input | 1 | Pulse: START or repeated START seen on the bus |
| bus_stop | input | 1 | Pulse: STOP seen on the bus |
| wr_protect | input | 1 | High blocks every commit |
| cycle_len | input | TIME_W | Total programming time in clocks |
| busy | output | 1 | Programming cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| commit_done | output | 1 | One-clock pulse at the end of a commit |

## Verification
On every clock, the assertions check that array writes occur only under busy, that consecutive writes stay inside one page, that erase-phase writes carry all ones, that the busy window length matches the sampled cycle length, that a protected STOP never raises busy, and that the done pulse is a single clock right after busy falls. Which offsets get written and with which data depends on the sequence of bytes, so only the bench scenarios show it. These scenarios cover page wrap, overflow replacement, and discard on START or on a byte-less STOP. They also show that inputs are ignored during busy and that valid marks clear between transactions, with the results read back from a shadow copy of the array.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_ERASE,
        ST_PROG
    } pgw_state_e;
endpackage

// File: rtl/pgw_latch_bank.sv
// Page buffer: one data latch and one valid mark per page offset.
module pgw_latch_bank #(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } slot_t;

    logic [SLOTS-1:0]             valid_vec;
    logic [SLOTS-1:0][DATA_W-1:0] data_vec;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr) begin
                slot_d.valid = 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(s))) begin
                slot_d.valid = 1'b1;
                slot_d.data  = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign valid_vec[s] = slot_q.valid;
        assign data_vec[s]  = slot_q.data;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_data  = data_vec[rd_idx];
endmodule

// File: rtl/pgw_phase_timer.sv
// Phase counter: length loaded on arm, counts while run, wraps at phase end.
module pgw_phase_timer #(
    parameter int TIME_W    = 20,
    parameter int MIN_PHASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [TIME_W-1:0] len_in,
    input  logic              run,
    output logic [TIME_W-1:0] cnt,
    output logic              last
);
    typedef struct packed {
        logic [TIME_W-1:0] cnt;
        logic [TIME_W-1:0] plen;
    } tmr_t;

    tmr_t              tmr_d, tmr_q;
    logic [TIME_W-1:0] half;
    logic              at_end;

    assign half   = len_in >> 1;
    assign at_end = (tmr_q.cnt == (tmr_q.plen - TIME_W'(1)));

    always_comb begin
        tmr_d = tmr_q;
        if (arm) begin
            tmr_d.cnt  = '0;
            tmr_d.plen = (half < TIME_W'(MIN_PHASE)) ? TIME_W'(MIN_PHASE) : half;
        end else if (run) begin
            tmr_d.cnt = at_end ? '0 : tmr_q.cnt + TIME_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.cnt  <= '0;
            tmr_q.plen <= TIME_W'(MIN_PHASE);
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign cnt  = tmr_q.cnt;
    assign last = run && at_end;
endmodule

// File: rtl/page_commit_engine.sv
// Collects one write transaction into a page buffer and commits it at STOP
// through a timed erase phase followed by a timed program phase.
module page_commit_engine
    import pgw_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int TIME_W     = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_write,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              wr_protect,
    input  logic [TIME_W-1:0] cycle_len,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              commit_done
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int UP_W  = ADDR_W - OFF_W;

    typedef struct packed {
        pgw_state_e        state;
        logic [UP_W-1:0]   base;
        logic [OFF_W-1:0]  ptr;
        logic              got;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              bank_clr;
    logic              bank_we;
    logic [DATA_W-1:0] bank_rdata;
    logic              bank_rvalid;
    logic              tmr_arm;
    logic              tmr_run;
    logic [TIME_W-1:0] tmr_cnt;
    logic              tmr_last;
    logic              in_sweep;

    pgw_latch_bank #(
        .SLOTS  (PAGE_BYTES),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (bank_clr),
        .wr_en    (bank_we),
        .wr_idx   (ctl_q.ptr),
        .wr_data  (byte_data),
        .rd_idx   (tmr_cnt[OFF_W-1:0]),
        .rd_data  (bank_rdata),
        .rd_valid (bank_rvalid)
    );

    pgw_phase_timer #(
        .TIME_W    (TIME_W),
        .MIN_PHASE (PAGE_BYTES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (tmr_arm),
        .len_in (cycle_len),
        .run    (tmr_run),
        .cnt    (tmr_cnt),
        .last   (tmr_last)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        bank_clr   = 1'b0;
        bank_we    = 1'b0;
        tmr_arm    = 1'b0;
        tmr_run    = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (open_write) begin
                    ctl_d.state = ST_FILL;
                    ctl_d.base  = word_addr[ADDR_W-1:OFF_W];
                    ctl_d.ptr   = word_addr[OFF_W-1:0];
                    ctl_d.got   = 1'b0;
                    bank_clr    = 1'b1;
                end
            end
            ST_FILL: begin
                if (bus_stop) begin
                    if (ctl_q.got && !wr_protect) begin
                        ctl_d.state = ST_ERASE;
                        tmr_arm     = 1'b1;
                    end else begin
                        ctl_d.state = ST_IDLE;
                    end
                end else if (bus_start) begin
                    ctl_d.state = ST_IDLE;
                end else if (open_write) begin
                    ctl_d.base = word_addr[ADDR_W-1:OFF_W];
                    ctl_d.ptr  = word_addr[OFF_W-1:0];
                    ctl_d.got  = 1'b0;
                    bank_clr   = 1'b1;
                end else if (byte_valid) begin
                    bank_we   = 1'b1;
                    ctl_d.ptr = ctl_q.ptr + OFF_W'(1);
                    ctl_d.got = 1'b1;
                end
            end
            ST_ERASE: begin
                tmr_run = 1'b1;
                if (tmr_last) ctl_d.state = ST_PROG;
            end
            ST_PROG: begin
                tmr_run = 1'b1;
                if (tmr_last) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.base  <= '0;
            ctl_q.ptr   <= '0;
            ctl_q.got   <= 1'b0;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy        = (ctl_q.state == ST_ERASE) || (ctl_q.state == ST_PROG);
    assign in_sweep    = (tmr_cnt < TIME_W'(PAGE_BYTES));
    assign arr_we      = busy && in_sweep && bank_rvalid;
    assign arr_addr    = {ctl_q.base, tmr_cnt[OFF_W-1:0]};
    assign arr_wdata   = (ctl_q.state == ST_ERASE) ? {DATA_W{1'b1}} : bank_rdata;
    assign commit_done = ctl_q.done;
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int TIME_W     = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_stop,
    input logic              wr_protect,
    input logic [TIME_W-1:0] cycle_len,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [DATA_W-1:0] arr_wdata,
    input logic              commit_done
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic [TIME_W-1:0] len_seen;
    logic [TIME_W-1:0] ph_exp;
    logic [TIME_W+1:0] bcnt;
    logic              busy_prev;
    logic [TIME_W-1:0] len_half;

    assign len_half = len_seen >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_seen  <= '0;
            ph_exp    <= TIME_W'(PAGE_BYTES);
            bcnt      <= '0;
            busy_prev <= 1'b0;
        end else begin
            len_seen  <= cycle_len;
            busy_prev <= busy;
            bcnt      <= busy ? bcnt + 1'b1 : '0;
            if (busy && !busy_prev)
                ph_exp <= (len_half < TIME_W'(PAGE_BYTES)) ? TIME_W'(PAGE_BYTES) : len_half;
        end
    end

    // R4
    a_r4_we_under_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R2
    a_r2_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
            (arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W])));

    // R5
    a_r5_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && ((bcnt == '0) || (bcnt < {2'b00, ph_exp}))) |-> (arr_wdata == {DATA_W{1'b1}}));

    // R6
    a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == ({2'b00, ph_exp} << 1)));

    // R7
    a_r7_protect_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && wr_protect && !busy) |=> !busy);

    // R10
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |=> !commit_done);

    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> (!busy && $past(busy)));
endmodule

bind page_commit_engine pgw_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES),
    .TIME_W     (TIME_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_stop    (bus_stop),
    .wr_protect  (wr_protect),
    .cycle_len   (cycle_len),
    .busy        (busy),
    .arr_we      (arr_we),
    .arr_addr    (arr_addr),
    .arr_wdata   (arr_wdata),
    .commit_done (commit_done)
);

// File: tb/sim_page_commit_engine.sv
`timescale 1ns/1ps
module sim_page_commit_engine;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int PAGE   = 8;
    localparam int TIME_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              open_write = 1'b0;
    logic [ADDR_W-1:0] word_addr = '0;
    logic              byte_valid = 1'b0;
    logic [DATA_W-1:0] byte_data = '0;
    logic              bus_start = 1'b0;
    logic              bus_stop = 1'b0;
    logic              wr_protect = 1'b0;
    logic [TIME_W-1:0] cycle_len = TIME_W'(20);
    logic              busy;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_wdata;
    logic              commit_done;

    page_commit_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE), .TIME_W(TIME_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .open_write(open_write), .word_addr(word_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .bus_start(bus_start),
        .bus_stop(bus_stop), .wr_protect(wr_protect), .cycle_len(cycle_len),
        .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .commit_done(commit_done)
    );

    always #4 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct {
        int at;
        int addr;
        int data;
    } ev_t;

    ev_t evq[$];
    bit  m_open = 0;
    int  m_base = 0;
    int  m_pos  = 0;
    int  m_lat[PAGE];
    bit  m_has[PAGE];
    bit  m_got = 0;
    int  m_left = 0;
    int  m_elapsed = 0;
    bit  m_done = 0;

    task automatic m_begin(int a);
        m_open = 1;
        m_base = a - (a % PAGE);
        m_pos  = a % PAGE;
        m_got  = 0;
        foreach (m_has[i]) m_has[i] = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_open = 0; m_left = 0; m_done = 0; m_got = 0; evq.delete();
        end else begin
            m_done = 0;
            if (m_left > 0) begin
                m_elapsed++;
                m_left--;
                if (m_left == 0) m_done = 1;
            end else if (m_open && bus_stop) begin
                m_open = 0;
                if (m_got && !wr_protect) begin
                    int p;
                    p = int'(cycle_len) / 2;
                    if (p < PAGE) p = PAGE;
                    for (int s = 0; s < PAGE; s++)
                        if (m_has[s]) evq.push_back('{s, m_base + s, 255});
                    for (int s = 0; s < PAGE; s++)
                        if (m_has[s]) evq.push_back('{p + s, m_base + s, m_lat[s]});
                    m_left = 2 * p;
                    m_elapsed = 0;
                end
            end else if (m_open && bus_start) begin
                m_open = 0;
            end else if (open_write) begin
                m_begin(int'(word_addr));
            end else if (m_open && byte_valid) begin
                m_lat[m_pos] = int'(byte_data);
                m_has[m_pos] = 1;
                m_pos = (m_pos + 1) % PAGE;
                m_got = 1;
            end
        end
    end

    // ---------------- per-clock comparison and shadow array ----------------
    int arr[256];
    int we_cnt = 0;
    int busy_run = 0;
    int last_busy_len = 0;

    initial foreach (arr[i]) arr[i] = -1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            bit exp_we;
            exp_we = (m_left > 0) && (evq.size() > 0) && (evq[0].at == m_elapsed);
            chk("R6 busy", int'(busy), int'(m_left > 0));
            chk("R10 commit_done", int'(commit_done), int'(m_done));
            chk("R4 arr_we", int'(arr_we), int'(exp_we));
            if (exp_we && arr_we) begin
                chk("R2 arr_addr", int'(arr_addr), evq[0].addr);
                chk("R5 arr_wdata", int'(arr_wdata), evq[0].data);
            end
            if (exp_we) void'(evq.pop_front());
            if (arr_we) begin
                arr[arr_addr] = int'(arr_wdata);
                we_cnt++;
            end
            if (busy) busy_run++;
            else if (busy_run != 0) begin
                last_busy_len = busy_run;
                busy_run = 0;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic op_open(int a);
        open_write = 1; word_addr = ADDR_W'(a);
        @(negedge clk); open_write = 0;
    endtask

    task automatic op_byte(int d);
        byte_valid = 1; byte_data = DATA_W'(d);
        @(negedge clk); byte_valid = 0;
    endtask

    task automatic op_stop();
        bus_stop = 1;
        @(negedge clk); bus_stop = 0;
    endtask

    task automatic op_start();
        bus_start = 1;
        @(negedge clk); bus_start = 0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        wait (cyc > 150000);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 arr_we", int'(arr_we), 0);
        chk("R1 commit_done", int'(commit_done), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy after release", int'(busy), 0);

        // R2, R6: single byte, cycle_len 20 -> 20 busy clocks
        we_cnt = 0;
        op_open(8'h13); op_byte(8'hA5); op_stop();
        settle();
        chk("R2 single byte", arr[8'h13], 8'hA5);
        chk("R6 busy length 20", last_busy_len, 20);
        chk("R4 single byte writes", we_cnt, 2);

        // R2: wrap within the page from offset 6
        op_open(8'h2E);
        for (int i = 0; i < 5; i++) op_byte(8'h10 + i);
        op_stop();
        settle();
        chk("R2 wrap 2E", arr[8'h2E], 8'h10);
        chk("R2 wrap 2F", arr[8'h2F], 8'h11);
        chk("R2 wrap 28", arr[8'h28], 8'h12);
        chk("R2 wrap 2A", arr[8'h2A], 8'h14);
        chk("R2 next page untouched", arr[8'h30], -1);

        // R3: eleven bytes into one page
        we_cnt = 0;
        op_open(8'h40);
        for (int i = 0; i < 11; i++) op_byte(8'h50 + i);
        op_stop();
        settle();
        chk("R3 overwritten 40", arr[8'h40], 8'h58);
        chk("R3 overwritten 42", arr[8'h42], 8'h5A);
        chk("R3 kept 43", arr[8'h43], 8'h53);
        chk("R3 kept 47", arr[8'h47], 8'h57);
        chk("R3 write count", we_cnt, 16);

        // R7: write protect at STOP
        we_cnt = 0;
        wr_protect = 1;
        op_open(8'h60); op_byte(8'h77); op_stop();
        wr_protect = 0;
        settle();
        chk("R7 protected location", arr[8'h60], -1);
        chk("R7 no writes", we_cnt, 0);

        // R8: STOP without a byte, and START before STOP
        we_cnt = 0;
        op_open(8'h70); op_stop();
        settle();
        op_open(8'h71); op_byte(8'h99); op_start(); op_stop();
        settle();
        chk("R8 no-byte stop", we_cnt, 0);
        chk("R8 start discards", arr[8'h71], -1);

        // R9: inputs during busy are ignored
        we_cnt = 0;
        op_open(8'h80); op_byte(8'h11); op_stop();
        op_open(8'h90); op_byte(8'h22); op_stop();
        settle();
        chk("R9 committed byte", arr[8'h80], 8'h11);
        chk("R9 ignored during busy", arr[8'h90], -1);
        chk("R9 write count", we_cnt, 2);

        // R11: valid marks cleared between transactions
        we_cnt = 0;
        op_open(8'h45); op_byte(8'hC3); op_stop();
        settle();
        chk("R11 new byte", arr[8'h45], 8'hC3);
        chk("R11 old neighbour kept", arr[8'h40], 8'h58);
        chk("R11 write count", we_cnt, 2);

        // R6: floor at one page of clocks, long cycle, change during busy
        cycle_len = TIME_W'(4);
        op_open(8'hA0); op_byte(8'h01); op_stop();
        settle();
        chk("R6 floor length 16", last_busy_len, 16);
        cycle_len = TIME_W'(101);
        op_open(8'hA1); op_byte(8'h02); op_byte(8'h03); op_stop();
        cycle_len = TIME_W'(2);
        settle();
        chk("R6 length 100 held", last_busy_len, 100);
        chk("R5 program data", arr[8'hA2], 8'h03);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule